// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block supervises a small microcontroller. A 16-bit counter advances on each pulse of a 32.768 kHz tick enable while the watchdog is switched on. If software does not re-arm the watchdog within the selected window, the block acts. It either pulses a reset request or raises an interrupt request that the global interrupt enable cannot mask. The event is also recorded in a sticky status bit. With the interrupt action selected, the counter restarts after every expiry, so the block doubles as a periodic timer.

All configuration lives in one 8-bit register on a simple strobe bus. A write changes the register only when it directly follows an unlock write, so a stray store cannot disable the watchdog. The `rst` input is the external hardware reset. A reset raised by the watchdog itself clears only the enable bit and leaves the status bit set. A supply-monitor event input also switches the watchdog off.

Top module: `wdt_guard`

## Requirements
- R1: After `rst` the register reads 0x10 (layout, MSB first: window select [7:4], action select [3], status [2], enable [1], unlock [0]). `rst_req` and `nmi_req` are low.
- R2: A register write (`bus_stb`, `bus_we` and `bus_hit` all high) with bit 0 set is an unlock. It changes no field, and bit 0 always reads 0. The next bus cycle, if it is a register write, loads the window select, action select and enable fields.
- R3: A register write that does not directly follow an unlock bus cycle is ignored. A read cycle or a write to another address between the unlock and the data write cancels the unlock. Idle cycles (`bus_stb` low) do not cancel it.
- R4: For a window select value S from 0 to 7, the expiry comes 2^(S+9) tick pulses after the enable write. Cycles with `tick_en` low do not count.
- R5: Writing enable = 1 again restarts the count from zero.
- R6: With action select 0, an expiry gives a one-cycle `rst_req`, clears enable and sets status.
- R7: With action select 1, an expiry sets status, leaves enable at 1, restarts the count, and raises `nmi_req`. `nmi_req` stays high until `nmi_ack`.
- R8: A window select of 8 or more, together with enable, gives `rst_req` one cycle later, whatever the action select is.
- R9: Status is set by every expiry. Writing 0 clears it, and writing 1 leaves it unchanged. A watchdog reset keeps it set, and `rst` clears it.
- R10: `psm_evt` clears enable. With enable at 0, no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| tick_en | input | 1 | One-cycle pulse at 32.768 kHz |
| bus_stb | input | 1 | A bus cycle is in progress |
| bus_we | input | 1 | The bus cycle is a write |
| bus_hit | input | 1 | The bus cycle addresses this register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| psm_evt | input | 1 | Supply-monitor event; clears enable |
| nmi_ack | input | 1 | Acknowledges the interrupt request |
| rst_req | output | 1 | One-cycle system reset request |
| nmi_req | output | 1 | Non-maskable interrupt request, level |

## Verification
On every cycle the assertions check the following:
- the reset request lasts exactly one cycle and comes with enable cleared;
- the status bit is set whenever a request appears;
- the interrupt request holds until it is acknowledged;
- the immediate-reset codes act on the next cycle;
- a supply-monitor event clears enable;
- a non-unlock bus cycle blocks the next write;
- the counter never passes its limit.

Only the bench scenarios can show the exact window length for each select code and the restart after a re-arm. They also show the cancellation by reads and foreign writes, the periodic interrupt spacing, and the write semantics of the status bit.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int CNT_W       = 16;
    localparam int PRE_W       = 4;
    localparam int BASE_SHIFT  = 9;
    localparam int NUM_PERIODS = 8;
    localparam int SEL_W       = $clog2(NUM_PERIODS);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             intsel;
        logic             status;
        logic             en;
    } ctrl_t;

    localparam int REG_W = $bits(ctrl_t) + 1;

    localparam ctrl_t CTRL_RESET = '{pre: PRE_W'(1), intsel: 1'b0, status: 1'b0, en: 1'b0};

    typedef enum logic [1:0] {
        TMO_NONE,
        TMO_RESET,
        TMO_IRQ
    } tmo_kind_e;

    function automatic logic is_immediate(input logic [PRE_W-1:0] pre);
        return pre >= PRE_W'(NUM_PERIODS);
    endfunction

    function automatic logic [CNT_W-1:0] period_limit(input logic [SEL_W-1:0] sel);
        int sh;
        sh = int'(sel) + BASE_SHIFT;
        return CNT_W'(((CNT_W+1)'(1) << sh) - (CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock (
    input  logic clk,
    input  logic rst,
    input  logic bus_stb,
    input  logic bus_we,
    input  logic bus_hit,
    input  logic unlock_bit,
    output logic wr_ok
);
    logic armed_q;
    logic reg_wr;

    assign reg_wr = bus_stb && bus_we && bus_hit;
    assign wr_ok  = armed_q && reg_wr;

    // Any bus cycle consumes the arm; only an unlock write made while not armed re-arms.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (bus_stb) begin
            armed_q <= !armed_q && reg_wr && unlock_bit;
        end
    end

    // R3: a bus cycle that is not an unlock blocks a write in the next cycle
    assert_cancel_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !(reg_wr && unlock_bit)) |=> !wr_ok);

    // R2: an accepted write never arms the next one
    assert_no_chain_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> !wr_ok);

endmodule

// File: rtl/wdt_period_counter.sv
module wdt_period_counter
    import wdt_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             hold,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit  = period_limit(sel);
    assign expire = run && !hold && tick && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || clr || expire) begin
            cnt_q <= '0;
        end else if (tick && !hold) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the running count never passes the selected limit
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !hold) |-> (cnt_q <= limit));

    // R4: without a tick the count does not move
    assert_tick_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !clr && !hold && $past(run)) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       bus_stb,
    input  logic       bus_we,
    input  logic       bus_hit,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       psm_evt,
    input  logic       nmi_ack,
    output logic       rst_req,
    output logic       nmi_req
);
    ctrl_t     ctrl_q, ctrl_d, wr_fields;
    tmo_kind_e kind;
    logic      wr_ok, expire, imm;
    logic      rst_req_q, nmi_q;

    assign wr_fields = ctrl_t'(bus_wdata[REG_W-1:1]);
    assign imm       = is_immediate(ctrl_q.pre);

    wdt_unlock u_unlock (
        .clk        (clk),
        .rst        (rst),
        .bus_stb    (bus_stb),
        .bus_we     (bus_we),
        .bus_hit    (bus_hit),
        .unlock_bit (bus_wdata[0]),
        .wr_ok      (wr_ok)
    );

    wdt_period_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .run    (ctrl_q.en),
        .hold   (imm),
        .clr    (wr_ok && wr_fields.en),
        .sel    (ctrl_q.pre[SEL_W-1:0]),
        .expire (expire)
    );

    always_comb begin
        if (!ctrl_q.en)     kind = TMO_NONE;
        else if (imm)       kind = TMO_RESET;
        else if (expire)    kind = ctrl_q.intsel ? TMO_IRQ : TMO_RESET;
        else                kind = TMO_NONE;
    end

    // Priority: software write, then timeout effects, then supply-monitor clear.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ok) begin
            ctrl_d.pre    = wr_fields.pre;
            ctrl_d.intsel = wr_fields.intsel;
            ctrl_d.en     = wr_fields.en;
            ctrl_d.status = ctrl_q.status & wr_fields.status;
        end
        if (kind != TMO_NONE)  ctrl_d.status = 1'b1;
        if (kind == TMO_RESET) ctrl_d.en     = 1'b0;
        if (psm_evt)           ctrl_d.en     = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            rst_req_q <= 1'b0;
            nmi_q     <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            rst_req_q <= (kind == TMO_RESET);
            nmi_q     <= (kind == TMO_IRQ) || (nmi_q && !nmi_ack);
        end
    end

    assign bus_rdata = {ctrl_q, 1'b0};
    assign rst_req   = rst_req_q;
    assign nmi_req   = nmi_q;

    // R6: reset request is a single-cycle pulse
    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R6: a reset request comes with the watchdog switched off
    assert_rst_clears_en_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !ctrl_q.en);

    // R9: every request is recorded in the status bit
    assert_status_set_R9: assert property (@(posedge clk) disable iff (rst)
        (rst_req || $rose(nmi_req)) |-> ctrl_q.status);

    // R7: the interrupt request holds until acknowledged
    assert_nmi_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !nmi_ack) |=> nmi_req);

    // R8: reserved and immediate codes request reset on the next cycle
    assert_immediate_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && imm) |=> rst_req);

    // R10: a supply-monitor event switches the watchdog off
    assert_psm_R10: assert property (@(posedge clk) disable iff (rst)
        psm_evt |=> !ctrl_q.en);

endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       bus_stb = 1'b0, bus_we = 1'b0, bus_hit = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       psm_evt = 1'b0, nmi_ack = 1'b0;
    logic       rst_req, nmi_req;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wdt_guard dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_hit(bus_hit),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .psm_evt(psm_evt), .nmi_ack(nmi_ack),
        .rst_req(rst_req), .nmi_req(nmi_req)
    );

    // {window select[7:4], unused[3:1], action select[0]}
    localparam logic [7:0] VEC [0:5] = '{8'h00, 8'h11, 8'h20, 8'h31, 8'h80, 8'hC1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_cycle(input logic we, input logic hit, input logic [7:0] d);
        bus_stb = 1'b1; bus_we = we; bus_hit = hit; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0; bus_hit = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic guarded_write(input logic [7:0] d);
        bus_cycle(1'b1, 1'b1, 8'h01);
        bus_cycle(1'b1, 1'b1, d);
    endtask

    task automatic wait_event(input int cap, output int n, output logic r, output logic i);
        n = 0; r = 1'b0; i = 1'b0;
        while (n < cap && !r && !i) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            r = rst_req;
            i = nmi_req;
        end
    endtask

    task automatic quiet(input int cycles, input string req);
        int hits;
        hits = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (rst_req || nmi_req) hits++;
        end
        check(req, hits, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        logic r, i;
        logic [3:0] pre;
        logic isel;
        int exp_n;

        do_reset();
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h10);
        check("R1 rst_req", rst_req, 0);
        check("R1 nmi_req", nmi_req, 0);

        // R3: write without unlock ignored
        bus_cycle(1'b1, 1'b1, 8'h72);
        check("R3 no unlock", bus_rdata, 8'h10);
        // R2: unlock changes nothing and bit 0 reads 0
        bus_cycle(1'b1, 1'b1, 8'hF7);
        check("R2 unlock alone", bus_rdata, 8'h10);
        // R3: read in between cancels
        bus_cycle(1'b0, 1'b1, 8'h00);
        bus_cycle(1'b1, 1'b1, 8'h70);
        check("R3 read cancels", bus_rdata, 8'h10);
        // R3: foreign write in between cancels
        bus_cycle(1'b1, 1'b1, 8'h01);
        bus_cycle(1'b1, 1'b0, 8'h55);
        bus_cycle(1'b1, 1'b1, 8'h70);
        check("R3 other address cancels", bus_rdata, 8'h10);
        // R3: idle cycles keep the unlock; R2 accepted
        bus_cycle(1'b1, 1'b1, 8'h01);
        repeat (3) @(negedge clk);
        bus_cycle(1'b1, 1'b1, 8'h70);
        check("R2 accepted after idle", bus_rdata, 8'h70);
        // R10: disabled watchdog never expires
        guarded_write(8'h00);
        check("R10 disabled write", bus_rdata, 8'h00);
        quiet(700, "R10 disabled quiet");

        // R4 / R6 / R7 / R8 vector walk
        for (int v = 0; v < 6; v++) begin
            pre  = VEC[v][7:4];
            isel = VEC[v][0];
            do_reset();
            guarded_write({pre, isel, 1'b0, 1'b1, 1'b0});
            wait_event(70000, n, r, i);
            exp_n = (pre >= 4'd8) ? 1 : (1 << (int'(pre) + 9));
            check("R4/R8 period", n, exp_n);
            check("R6/R8 reset kind", r, (pre >= 4'd8) || !isel);
            check("R7 irq kind", i, (pre < 4'd8) && isel);
        end

        // R6 / R9: reset-mode expiry
        do_reset();
        guarded_write(8'h02);
        wait_event(70000, n, r, i);
        check("R6 rdata at reset", bus_rdata, 8'h04);
        @(negedge clk);
        check("R6 pulse width", rst_req, 0);
        quiet(700, "R6 stays off");
        guarded_write(8'h04);
        check("R9 write 1 keeps", bus_rdata, 8'h04);
        guarded_write(8'h00);
        check("R9 write 0 clears", bus_rdata, 8'h00);
        guarded_write(8'h04);
        check("R9 write 1 cannot set", bus_rdata, 8'h00);
        guarded_write(8'h02);
        wait_event(70000, n, r, i);
        do_reset();
        check("R9 hw reset clears", bus_rdata, 8'h10);

        // R7: interrupt mode
        do_reset();
        guarded_write(8'h0A);
        wait_event(70000, n, r, i);
        check("R7 first irq", n, 512);
        check("R7 rdata", bus_rdata, 8'h0E);
        repeat (100) @(negedge clk);
        check("R7 held", nmi_req, 1);
        nmi_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        nmi_ack = 1'b0;
        check("R7 acked", nmi_req, 0);
        wait_event(70000, n, r, i);
        check("R7 restart period", n + 101, 512);
        check("R7 second irq", i, 1);

        // R5: re-arming restarts the window
        do_reset();
        guarded_write(8'h02);
        for (int k = 0; k < 4; k++) begin
            quiet(400, "R5 kick quiet");
            guarded_write(8'h02);
        end
        wait_event(70000, n, r, i);
        check("R5 after last kick", n, 512);

        // R10: supply-monitor event
        do_reset();
        guarded_write(8'h02);
        repeat (100) @(negedge clk);
        psm_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psm_evt = 1'b0;
        check("R10 psm clears enable", bus_rdata, 8'h00);
        quiet(700, "R10 psm quiet");

        // R4: tick gating
        do_reset();
        tick_en = 1'b0;
        guarded_write(8'h02);
        quiet(1000, "R4 no ticks");
        tick_en = 1'b1;
        wait_event(70000, n, r, i);
        check("R4 ticks only", n, 512);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule